// File: doc/BRIEF.md
# SPI Command Engine With Shared Byte Buffer

This block is a half-duplex SPI master driven through a small byte-wide register bank. Software programs a command byte, how many payload bytes go out, how many bytes come back and which of four targets to address. It places the outgoing payload in a byte-addressed buffer window and then sets a start bit. From there the engine needs no help. It pulls the selected chip select low, shifts out the command byte and then the payload, and reads the requested number of bytes back into the buffer. Chip select is released and busy drops when the last byte is done.

The buffer is shared by both directions. An internal buffer pointer advances once for every payload byte sent and once for every byte received. Received bytes therefore land directly after the payload. A pointer-reset bit rewinds the pointer to location 0. The pointer is not rewound by a start, so a command issued without a rewind continues from where the previous one stopped. The serial clock idles low. Data changes on its falling edge and is sampled on its rising edge, most significant bit first. The serial clock is the system clock divided by 2*HALF_DIV.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the busy flag (bit 7 at offset 0x03) reads 0, every chip select output is high and the serial clock is low.
- R2: The command byte at offset 0x00, the payload count at 0x48 and the return count at 0x4B read back as written. The target select at 0x1D reads back bits 1:0 as written and 0 in bits 7:2.
- R3: Writing offset 0x02 with bit 0 set while idle starts a command. Busy reads 1 from the next cycle on and stays 1 for exactly 16*HALF_DIV*(1+TX+RX) cycles.
- R4: The command byte is sent first and is not counted in TX. It is followed by TX bytes taken from successive buffer locations starting at the pointer. Each byte goes out MSB first, and MOSI is stable while the serial clock is high.
- R5: During the return phase MOSI sends 0x00 bytes. The RX bytes sampled on MISO are stored at buffer locations pointer+TX onward.
- R6: For the whole command exactly the selected chip select (low when active) is low, and it does not change. All chip selects are high when idle.
- R7: Writing offset 0x02 with bit 4 set while idle rewinds the pointer to 0. When bits 0 and 4 are written together, the rewind applies before the start. Without a rewind, a command starts at the location after the previous command's last byte.
- R8: A start or rewind written while busy is ignored. The running command keeps its length, and the pointer is not rewound.
- R9: The start and rewind bits do not hold: offset 0x02 always reads 0.
- R10: Offsets 0x80+i for i below the buffer depth read and write buffer byte i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |
| spi_cs_n_o | output | CS_NUM | Chip selects, active low |

## Verification
Busy becomes visible on the first read after the clock edge that takes the start write. Each byte then takes exactly 16*HALF_DIV clocks, with no gap between bytes. The bench therefore counts the clock cycles with a chip select low and expects 16*HALF_DIV*(1+TX+RX) for each command. A slave model in the bench captures MOSI on serial-clock rising edges. It drives MISO only on falling edges, so each bit is stable for HALF_DIV clocks before the engine samples it. Buffer contents are read only after busy has read back as 0. The sweep covers every TX and RX count from 0 to 4.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam logic [7:0] OFS_OPCODE = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h02;
    localparam logic [7:0] OFS_STAT   = 8'h03;
    localparam logic [7:0] OFS_CSSEL  = 8'h1D;
    localparam logic [7:0] OFS_TXCNT  = 8'h48;
    localparam logic [7:0] OFS_RXCNT  = 8'h4B;
    localparam int START_BIT  = 0;
    localparam int REWIND_BIT = 4;

    typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_TX, PH_RX} phase_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [7:0]    rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [7:0]    rdata_b_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_byte_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_byte_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic          active;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic          sclk;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } shf_t;

    shf_t sh_d, sh_q;
    logic tick;

    always_comb begin
        sh_d   = sh_q;
        done_o = 1'b0;
        tick   = sh_q.active && (sh_q.div == DIV_LAST);
        if (sh_q.active) sh_d.div = tick ? '0 : sh_q.div + 1'b1;
        if (tick) begin
            if (!sh_q.sclk) begin
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[6:0], miso_i};
            end else begin
                sh_d.sclk = 1'b0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.active = 1'b0;
                    done_o      = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                    sh_d.sh   = {sh_q.sh[6:0], 1'b0};
                end
            end
        end
        if (start_i) begin
            sh_d.active = 1'b1;
            sh_d.div    = '0;
            sh_d.bitn   = '0;
            sh_d.sclk   = 1'b0;
            sh_d.sh     = tx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sclk_o    = sh_q.sclk;
    assign mosi_o    = sh_q.active & sh_q.sh[7];
    assign rx_byte_o = sh_q.rx;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int AW  = 4,
    parameter int CSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           rewind_i,
    input  logic [7:0]     opcode_i,
    input  logic [7:0]     txcnt_i,
    input  logic [7:0]     rxcnt_i,
    input  logic [CSW-1:0] cs_sel_i,
    input  logic [7:0]     fifo_rdata_i,
    input  logic           sh_done_i,
    input  logic [7:0]     sh_rx_i,
    output logic           busy_o,
    output logic [CSW-1:0] cs_sel_o,
    output logic           sh_start_o,
    output logic [7:0]     sh_tx_o,
    output logic [AW-1:0]  ptr_o,
    output logic           fifo_we_o
);
    typedef struct packed {
        phase_e         ph;
        logic [AW-1:0]  ptr;
        logic [7:0]     tx_left;
        logic [7:0]     rx_left;
        logic [CSW-1:0] cs;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d       = sq_q;
        sh_start_o = 1'b0;
        sh_tx_o    = 8'h00;
        fifo_we_o  = 1'b0;
        unique case (sq_q.ph)
            PH_IDLE: begin
                if (rewind_i) sq_d.ptr = '0;
                if (start_i) begin
                    sq_d.ph      = PH_OPC;
                    sq_d.tx_left = txcnt_i;
                    sq_d.rx_left = rxcnt_i;
                    sq_d.cs      = cs_sel_i;
                    sh_start_o   = 1'b1;
                    sh_tx_o      = opcode_i;
                end
            end
            PH_OPC, PH_TX: begin
                if (sh_done_i) begin
                    if (sq_q.tx_left != 8'd0) begin
                        sh_start_o   = 1'b1;
                        sh_tx_o      = fifo_rdata_i;
                        sq_d.ptr     = sq_q.ptr + 1'b1;
                        sq_d.tx_left = sq_q.tx_left - 8'd1;
                        sq_d.ph      = PH_TX;
                    end else if (sq_q.rx_left != 8'd0) begin
                        sh_start_o = 1'b1;
                        sq_d.ph    = PH_RX;
                    end else begin
                        sq_d.ph = PH_IDLE;
                    end
                end
            end
            PH_RX: begin
                if (sh_done_i) begin
                    fifo_we_o    = 1'b1;
                    sq_d.ptr     = sq_q.ptr + 1'b1;
                    sq_d.rx_left = sq_q.rx_left - 8'd1;
                    if (sq_q.rx_left != 8'd1) sh_start_o = 1'b1;
                    else                      sq_d.ph    = PH_IDLE;
                end
            end
            default: sq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{ph: PH_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign busy_o   = (sq_q.ph != PH_IDLE);
    assign cs_sel_o = sq_q.cs;
    assign ptr_o    = sq_q.ptr;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int HALF_DIV   = 2,
    parameter int CS_NUM     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              spi_sclk_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic [CS_NUM-1:0] spi_cs_n_o
);
    localparam int AW  = $clog2(FIFO_DEPTH);
    localparam int CSW = $clog2(CS_NUM);

    typedef struct packed {
        logic [7:0]     opcode;
        logic [7:0]     txcnt;
        logic [7:0]     rxcnt;
        logic [CSW-1:0] cs;
    } regs_t;

    regs_t rg_d, rg_q;
    logic exec_req, rewind_req, busy, seq_we, sh_start, sh_done, bus_fifo_wr;
    logic [CSW-1:0] cs_act;
    logic [AW-1:0]  ptr;
    logic [7:0]     sh_tx, sh_rx, fifo_bus_rd, fifo_seq_rd;

    always_comb begin
        rg_d        = rg_q;
        exec_req    = 1'b0;
        rewind_req  = 1'b0;
        bus_fifo_wr = bus_wr_i & bus_addr_i[7];
        if (bus_wr_i && !bus_addr_i[7]) begin
            unique case (bus_addr_i)
                OFS_OPCODE: rg_d.opcode = bus_wdata_i;
                OFS_TXCNT:  rg_d.txcnt  = bus_wdata_i;
                OFS_RXCNT:  rg_d.rxcnt  = bus_wdata_i;
                OFS_CSSEL:  rg_d.cs     = bus_wdata_i[CSW-1:0];
                OFS_CTRL: begin
                    exec_req   = bus_wdata_i[START_BIT];
                    rewind_req = bus_wdata_i[REWIND_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata_o = 8'h00;
        if (bus_addr_i[7]) begin
            bus_rdata_o = fifo_bus_rd;
        end else begin
            unique case (bus_addr_i)
                OFS_OPCODE: bus_rdata_o = rg_q.opcode;
                OFS_STAT:   bus_rdata_o = {busy, 7'b0};
                OFS_CSSEL:  bus_rdata_o = {{(8-CSW){1'b0}}, rg_q.cs};
                OFS_TXCNT:  bus_rdata_o = rg_q.txcnt;
                OFS_RXCNT:  bus_rdata_o = rg_q.rxcnt;
                default:    bus_rdata_o = 8'h00;
            endcase
        end
    end

    spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW)) fifo_i (
        .clk       (clk),
        .we_i      (seq_we | bus_fifo_wr),
        .waddr_i   (seq_we ? ptr : bus_addr_i[AW-1:0]),
        .wdata_i   (seq_we ? sh_rx : bus_wdata_i),
        .raddr_a_i (bus_addr_i[AW-1:0]),
        .rdata_a_o (fifo_bus_rd),
        .raddr_b_i (ptr),
        .rdata_b_o (fifo_seq_rd)
    );

    spi_cmd_seq #(.AW(AW), .CSW(CSW)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (exec_req),
        .rewind_i     (rewind_req),
        .opcode_i     (rg_q.opcode),
        .txcnt_i      (rg_q.txcnt),
        .rxcnt_i      (rg_q.rxcnt),
        .cs_sel_i     (rg_q.cs),
        .fifo_rdata_i (fifo_seq_rd),
        .sh_done_i    (sh_done),
        .sh_rx_i      (sh_rx),
        .busy_o       (busy),
        .cs_sel_o     (cs_act),
        .sh_start_o   (sh_start),
        .sh_tx_o      (sh_tx),
        .ptr_o        (ptr),
        .fifo_we_o    (seq_we)
    );

    spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (sh_start),
        .tx_byte_i (sh_tx),
        .miso_i    (spi_miso_i),
        .sclk_o    (spi_sclk_o),
        .mosi_o    (spi_mosi_o),
        .done_o    (sh_done),
        .rx_byte_o (sh_rx)
    );

    for (genvar gi = 0; gi < CS_NUM; gi++) begin : g_cs
        assign spi_cs_n_o[gi] = !(busy && (cs_act == CSW'(gi)));
    end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int CS_NUM = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              exec_req,
    input logic [CS_NUM-1:0] cs_n,
    input logic              sclk,
    input logic              mosi
);
    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R6
    cs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));
    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && exec_req) |=> busy);
    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CS_NUM(CS_NUM)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .exec_req (exec_req),
    .cs_n     (spi_cs_n_o),
    .sclk     (spi_sclk_o),
    .mosi     (spi_mosi_o)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
    localparam int HALF = 2;
    localparam int BYTE_CYC = 16 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic sclk, mosi, miso = 1'b0;
    logic [3:0] cs_n;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    spi_cmd_engine #(.FIFO_DEPTH(16), .HALF_DIV(HALF), .CS_NUM(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .spi_sclk_o(sclk),
        .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_n_o(cs_n)
    );

    // slave model
    logic [7:0] seed = 8'h3C;
    logic [7:0] cap [64];
    logic [7:0] shv = 8'h00;
    logic [3:0] cs_seen = 4'hF;
    int g = 0, nbytes = 0, low_cyc = 0;
    wire cs_any_n = &cs_n;

    function automatic logic [7:0] resp(input int k);
        return 8'(k * 29) + seed;
    endfunction

    always @(negedge cs_any_n) begin
        logic [7:0] r;
        g = 0; nbytes = 0; cs_seen = cs_n;
        r = resp(0); miso = r[7];
    end
    always @(posedge sclk) if (!cs_any_n) begin
        shv = {shv[6:0], mosi};
        if (g % 8 == 7) begin cap[(g / 8) & 63] = shv; nbytes = g / 8 + 1; end
    end
    always @(negedge sclk) if (!cs_any_n) begin
        logic [7:0] r;
        g++;
        r = resp(g / 8); miso = r[7 - (g % 8)];
    end
    always @(negedge clk) if (rst_n && !cs_any_n) low_cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); bus_wr = 1'b0; bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int k = 0; k < 4000; k++) begin
            bus_read(8'h03, v);
            if (!v[7]) break;
        end
    endtask

    // mode 0: start only, 1: rewind then start, 2: rewind+start in one write
    task automatic run_cmd(input logic [7:0] opc, input int tx, input int rx,
                           input int sel, input int mode, input bit poke);
        logic [7:0] v;
        bus_write(8'h00, opc);
        bus_write(8'h48, 8'(tx));
        bus_write(8'h4B, 8'(rx));
        bus_write(8'h1D, 8'(sel));
        if (mode == 1) bus_write(8'h02, 8'h10);
        low_cyc = 0;
        bus_write(8'h02, (mode == 2) ? 8'h11 : 8'h01);
        bus_read(8'h03, v);
        chk(v == 8'h80, "R3 busy after start", v, 8'h80);
        if (poke) bus_write(8'h02, 8'h11); // R8 start+rewind while busy
        wait_idle();
        chk(low_cyc == BYTE_CYC * (1 + tx + rx), poke ? "R8 length unchanged" : "R3 busy length",
            low_cyc, BYTE_CYC * (1 + tx + rx));
        chk(cs_seen == ~(4'(1) << sel), "R6 chip select", cs_seen, ~(4'(1) << sel));
        chk(nbytes == 1 + tx + rx, "R4 byte count", nbytes, 1 + tx + rx);
        chk(cap[0] == opc, "R4 command byte first", cap[0], opc);
        for (int j = 0; j < rx; j++)
            chk(cap[1 + tx + j] == 8'h00, "R5 mosi zero in return phase", cap[1 + tx + j], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(8'h03, v);
        chk(v == 8'h00, "R1 busy at reset", v, 0);
        chk(cs_n == 4'hF, "R1 chip selects at reset", cs_n, 4'hF);
        chk(sclk == 1'b0, "R1 sclk at reset", sclk, 0);

        // R2 register readback
        bus_write(8'h00, 8'h5A); bus_read(8'h00, v); chk(v == 8'h5A, "R2 command byte", v, 8'h5A);
        bus_write(8'h48, 8'hC7); bus_read(8'h48, v); chk(v == 8'hC7, "R2 tx count", v, 8'hC7);
        bus_write(8'h4B, 8'h39); bus_read(8'h4B, v); chk(v == 8'h39, "R2 rx count", v, 8'h39);
        bus_write(8'h1D, 8'hFE); bus_read(8'h1D, v); chk(v == 8'h02, "R2 target select", v, 8'h02);

        // R10 buffer window
        for (int i = 0; i < 16; i++) bus_write(8'(8'h80 + i), 8'(i * 53 + 7));
        for (int i = 0; i < 16; i++) begin
            bus_read(8'(8'h80 + i), v);
            chk(v == 8'(i * 53 + 7), "R10 buffer byte", v, 8'(i * 53 + 7));
        end

        // sweep over all tx/rx counts 0..4
        for (int tx = 0; tx < 5; tx++) begin
            for (int rx = 0; rx < 5; rx++) begin
                seed = 8'(tx * 11 + rx * 7 + 1);
                for (int i = 0; i < tx; i++) bus_write(8'(8'h80 + i), 8'(i * 17 + tx * 3 + rx + 1));
                run_cmd(8'(8'h10 + tx * 5 + rx), tx, rx, (tx + rx) % 4, ((tx + rx) % 2 == 1) ? 2 : 1, 1'b0);
                for (int i = 0; i < tx; i++)
                    chk(cap[1 + i] == 8'(i * 17 + tx * 3 + rx + 1), "R4 payload byte",
                        cap[1 + i], 8'(i * 17 + tx * 3 + rx + 1));
                for (int j = 0; j < rx; j++) begin
                    bus_read(8'(8'h80 + tx + j), v);
                    e = resp(1 + tx + j);
                    chk(v == e, "R5 returned byte stored after payload", v, e);
                end
            end
        end

        // R9 control bits do not hold
        bus_read(8'h02, v);
        chk(v == 8'h00, "R9 control reads zero", v, 0);

        // R7 continuation without rewind
        bus_write(8'h80, 8'h77);
        bus_write(8'h82, 8'hC3);
        seed = 8'h51;
        run_cmd(8'hA1, 1, 1, 1, 1, 1'b0);
        bus_read(8'h81, v); e = resp(2);
        chk(v == e, "R7 first command return at 1", v, e);
        seed = 8'h92;
        run_cmd(8'hA2, 1, 1, 2, 0, 1'b0);
        chk(cap[1] == 8'hC3, "R7 payload continues at 2", cap[1], 8'hC3);
        bus_read(8'h83, v); e = resp(2);
        chk(v == e, "R7 return continues at 3", v, e);

        // R8 start and rewind while busy ignored
        bus_write(8'h80, 8'h1E); bus_write(8'h81, 8'h2D);
        seed = 8'h0B;
        run_cmd(8'hB3, 2, 2, 3, 1, 1'b1);
        chk(cap[1] == 8'h1E && cap[2] == 8'h2D, "R8 payload intact", cap[1], 8'h1E);
        bus_read(8'h03, v);
        chk(v == 8'h00, "R8 no restart after command", v, 0);
        seed = 8'hE4;
        run_cmd(8'hB4, 0, 1, 0, 0, 1'b0);
        bus_read(8'h84, v); e = resp(1);
        chk(v == e, "R8 pointer not rewound", v, e);
        bus_read(8'h80, v);
        chk(v == 8'h1E, "R8 location 0 untouched", v, 8'h1E);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule